// File: doc/BRIEF.md
# Big-Endian Load/Store Alignment Unit

This unit sits between a 32-bit integer datapath and a 32-bit wide, byte-addressable, big-endian data memory. The effective address (base register plus the sign-extended 16-bit offset) is formed upstream and arrives here already added. The unit turns one access request into what the memory port needs: a word address, a per-byte write enable and store data already placed in the right byte lanes. For loads it takes the word the memory returns and produces the register value: the addressed byte, halfword or word, zero- or sign-extended.

Misaligned accesses raise no fault. The low address bits that a halfword or word access cannot use are cleared before anything else looks at them. Store data is copied into every lane the access size can reach, so only the write enable decides which bytes change. All four outputs are registered: a request presented before a rising clock edge shows its result right after that edge.

Top module: `lsa_align_top`

## Requirements
- R1: `memAddr` equals `effAddr` with bits 1 and 0 cleared, one clock after the request is sampled.
- R2: `accSize` encodes 2'b00 as byte, 2'b01 as halfword and 2'b10 as word; the spare code 2'b11 behaves exactly like word.
- R3: A byte store at offset k (`effAddr[1:0]`) drives `byteWe` with only bit 3-k set (bit 3 is lane bits 31:24), and drives `memWdata` with `storeVal[7:0]` copied into all four lanes.
- R4: A halfword store ignores `effAddr[0]`. Offset 0 or 1 gives `byteWe` 4'b1100, offset 2 or 3 gives 4'b0011, and `memWdata` carries `storeVal[15:0]` in both halves.
- R5: A word store gives `byteWe` 4'b1111 and `memWdata` equal to `storeVal` for every value of `effAddr[1:0]`.
- R6: When `isStore` is 0, `byteWe` is 4'b0000 whatever the size and address.
- R7: A byte load at offset k returns lane k of `memRdata` (offset 0 is bits 31:24, offset 3 is bits 7:0). With `loadUnsigned` 0 the byte is sign-extended (0xFF gives 0xFFFFFFFF); with `loadUnsigned` 1 it is zero-extended (0xFF gives 0x000000FF).
- R8: A halfword load ignores `effAddr[0]`. Offset 0 or 1 returns bits 31:16 and offset 2 or 3 returns bits 15:0, extended according to `loadUnsigned` as in R7.
- R9: A word load returns `memRdata` unchanged, whatever `loadUnsigned` and `effAddr[1:0]` are.
- R10: While `rstN` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| effAddr | input | 32 | Effective byte address of the access |
| accSize | input | 2 | Access size: 00 byte, 01 halfword, 10 or 11 word |
| loadUnsigned | input | 1 | 1 zero-extends byte or halfword loads, 0 sign-extends them |
| isStore | input | 1 | 1 for a store, 0 for a load |
| storeVal | input | 32 | Register value to be stored |
| memRdata | input | 32 | Word read from memory, big-endian lanes |
| memAddr | output | 32 | Word-aligned memory address |
| byteWe | output | 4 | Byte write enables, bit 3 is lane 31:24 |
| memWdata | output | 32 | Store data copied into its lanes |
| loadResult | output | 32 | Extended load value for the register file |

## Verification
The bench walks every byte offset for both stores and loads. A little-endian lane order would show as a mirrored `byteWe` or the wrong byte coming back. Halfword and word accesses are also sent at odd and misaligned offsets: a design that used the low bits instead of clearing them would pick a lane straddling two halves or shift word data. Byte and halfword values with the top bit set are loaded both signed and unsigned, which shows whether the sign bit of the wrong lane, or no sign bit at all, fills the upper bits. Loads with every size check that no write enable leaks out, and the spare size code is driven to show that it acts as a word access.

// File: rtl/lsa_align_pkg.sv
package lsa_align_pkg;

  localparam int LSA_DATA_W = 32;
  localparam int LSA_LANES  = LSA_DATA_W / 8;
  localparam int LSA_OFF_W  = $clog2(LSA_LANES);

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_SPARE = 2'b11
  } accSizeT;

  // strobes from control to datapath
  typedef struct packed {
    logic [LSA_LANES-1:0] laneWe;    // per-lane write enable, MSB lane first
    logic [LSA_OFF_W-1:0] laneIdx;   // forced-aligned offset, 0 = MSB lane
    logic                 pickByte;  // byte-wide access
    logic                 pickHalf;  // halfword access
    logic                 fillSign;  // extend with the sign bit
  } lsaStrobeT;

endpackage

// File: rtl/lsa_align_ctrl.sv
module lsa_align_ctrl
  import lsa_align_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [LSA_OFF_W-1:0] rawOffset,
  input  logic [1:0]           accSize,
  input  logic                 loadUnsigned,
  input  logic                 isStore,
  output lsaStrobeT            strobe
);

  accSizeT sizeCode;
  logic [LSA_OFF_W-1:0] alignedOff;
  logic [LSA_LANES-1:0] sizeMask;

  assign sizeCode = accSizeT'(accSize);

  always_comb begin
    strobe = '0;
    alignedOff = '0;
    sizeMask = '0;
    unique case (sizeCode)
      SZ_BYTE: begin
        alignedOff = rawOffset;
        sizeMask   = 4'b1000 >> rawOffset;
        strobe.pickByte = 1'b1;
      end
      SZ_HALF: begin
        alignedOff = {rawOffset[1], 1'b0};
        sizeMask   = rawOffset[1] ? 4'b0011 : 4'b1100;
        strobe.pickHalf = 1'b1;
      end
      default: begin
        // word and spare code: offset dropped completely (R2)
        alignedOff = '0;
        sizeMask   = '1;
      end
    endcase
    strobe.laneIdx  = alignedOff;
    strobe.laneWe   = isStore ? sizeMask : '0;
    strobe.fillSign = ~loadUnsigned;
  end

  // R2: byte and halfword selection never both active
  a_r2_one_width: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.pickByte && strobe.pickHalf));

  // R4: a halfword access always lands on an even lane index
  a_r4_half_even: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pickHalf |-> (strobe.laneIdx[0] == 1'b0));

endmodule

// File: rtl/lsa_align_dp.sv
module lsa_align_dp
  import lsa_align_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  lsaStrobeT             strobe,
  input  logic [ADDR_W-1:2]     wordPart,
  input  logic [LSA_DATA_W-1:0] storeVal,
  input  logic [LSA_DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [LSA_LANES-1:0]  byteWe,
  output logic [LSA_DATA_W-1:0] memWdata,
  output logic [LSA_DATA_W-1:0] loadResult
);

  localparam int HALF_W = LSA_DATA_W / 2;

  logic [7:0] laneByte [LSA_LANES];
  logic [7:0]            selByte;
  logic [HALF_W-1:0]     selHalf;
  logic [LSA_DATA_W-1:0] loadNext;
  logic [LSA_DATA_W-1:0] wdataNext;

  // lane 0 is the most significant byte (big-endian)
  for (genvar i = 0; i < LSA_LANES; i++) begin : g_lane
    assign laneByte[i] = memRdata[LSA_DATA_W-1-8*i -: 8];
  end

  assign selByte = laneByte[strobe.laneIdx];
  assign selHalf = strobe.laneIdx[1] ? memRdata[HALF_W-1:0]
                                     : memRdata[LSA_DATA_W-1:HALF_W];

  always_comb begin
    if (strobe.pickByte)
      loadNext = {{(LSA_DATA_W-8){strobe.fillSign & selByte[7]}}, selByte};
    else if (strobe.pickHalf)
      loadNext = {{(LSA_DATA_W-HALF_W){strobe.fillSign & selHalf[HALF_W-1]}}, selHalf};
    else
      loadNext = memRdata;
  end

  always_comb begin
    if (strobe.pickByte)
      wdataNext = {LSA_LANES{storeVal[7:0]}};
    else if (strobe.pickHalf)
      wdataNext = {2{storeVal[HALF_W-1:0]}};
    else
      wdataNext = storeVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr    <= '0;
      byteWe     <= '0;
      memWdata   <= '0;
      loadResult <= '0;
    end else begin
      memAddr    <= {wordPart, 2'b00};
      byteWe     <= strobe.laneWe;
      memWdata   <= wdataNext;
      loadResult <= loadNext;
    end
  end

  // R1: registered address follows the request word part
  a_r1_addr_word: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> memAddr[ADDR_W-1:2] == $past(wordPart) && memAddr[1:0] == 2'b00);

  // R3: a byte store enables exactly one lane
  a_r3_byte_onelane: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pickByte && |strobe.laneWe) |=> $countones(byteWe) == 1);

  // R6: no write enable follows a load request
  a_r6_load_nowe: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.laneWe == '0) |=> byteWe == '0);

  // R7: signed byte load with a set sign bit fills the upper bits with ones
  a_r7_sign_fill: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pickByte && strobe.fillSign && selByte[7]) |=> &loadResult[LSA_DATA_W-1:8]);

  // R9: a word access passes memory data through untouched
  a_r9_word_pass: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.pickByte && !strobe.pickHalf) |=> loadResult == $past(memRdata));

endmodule

// File: rtl/lsa_align_top.sv
module lsa_align_top
  import lsa_align_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] effAddr,
  input  logic [1:0]        accSize,
  input  logic              loadUnsigned,
  input  logic              isStore,
  input  logic [31:0]       storeVal,
  input  logic [31:0]       memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [3:0]        byteWe,
  output logic [31:0]       memWdata,
  output logic [31:0]       loadResult
);

  lsaStrobeT strobe;

  lsa_align_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .rawOffset    (effAddr[LSA_OFF_W-1:0]),
    .accSize      (accSize),
    .loadUnsigned (loadUnsigned),
    .isStore      (isStore),
    .strobe       (strobe)
  );

  lsa_align_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wordPart   (effAddr[ADDR_W-1:2]),
    .storeVal   (storeVal),
    .memRdata   (memRdata),
    .memAddr    (memAddr),
    .byteWe     (byteWe),
    .memWdata   (memWdata),
    .loadResult (loadResult)
  );

  // R10: outputs stay cleared while reset is held
  a_r10_reset_clear: assert property (@(posedge clk)
    !rstN |=> (byteWe == '0 && loadResult == '0) || !rstN);

endmodule

// File: tb/lsa_align_top_test.sv
module lsa_align_top_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] effAddr = '0;
  logic [1:0]  accSize = '0;
  logic        loadUnsigned = 1'b0;
  logic        isStore = 1'b0;
  logic [31:0] storeVal = '0;
  logic [31:0] memRdata = '0;
  logic [31:0] memAddr;
  logic [3:0]  byteWe;
  logic [31:0] memWdata;
  logic [31:0] loadResult;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;   // 250 MHz

  lsa_align_top uut (
    .clk(clk), .rstN(rstN), .effAddr(effAddr), .accSize(accSize),
    .loadUnsigned(loadUnsigned), .isStore(isStore), .storeVal(storeVal),
    .memRdata(memRdata), .memAddr(memAddr), .byteWe(byteWe),
    .memWdata(memWdata), .loadResult(loadResult)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // independent expectation of every output for one request
  task automatic run(input string tag, input logic [31:0] a, input logic [1:0] sz,
                     input logic uns, input logic st, input logic [31:0] sv,
                     input logic [31:0] rd);
    int size, off;
    logic [31:0] eMask, eData, eLoad, piece;
    size = (sz == 2'd3) ? 2 : int'(sz);
    off  = int'(a[1:0]);
    if (size == 1) off = off & 2;
    if (size == 2) off = 0;
    eMask = '0;
    if (st) eMask = (size == 0) ? (32'h8 >> off) : (size == 1) ? (32'hC >> off) : 32'hF;
    if (size == 0)      eData = sv[7:0] * 32'h01010101;
    else if (size == 1) eData = sv[15:0] * 32'h00010001;
    else                eData = sv;
    if (size == 0) begin
      piece = (rd >> (24 - 8*off)) & 32'hFF;
      eLoad = (!uns && piece[7]) ? (piece | 32'hFFFFFF00) : piece;
    end else if (size == 1) begin
      piece = (rd >> (16 - 8*off)) & 32'hFFFF;
      eLoad = (!uns && piece[15]) ? (piece | 32'hFFFF0000) : piece;
    end else eLoad = rd;
    @(negedge clk);
    effAddr = a; accSize = sz; loadUnsigned = uns; isStore = st;
    storeVal = sv; memRdata = rd;
    @(negedge clk);
    check({tag, " R1 addr"}, memAddr, a & 32'hFFFFFFFC);
    check({tag, " we"}, {28'd0, byteWe}, eMask);
    if (st) check({tag, " wdata"}, memWdata, eData);
    else    check({tag, " load"}, loadResult, eLoad);
  endtask

  task automatic testReset;
    @(negedge clk);
    effAddr = 32'h1234_5677; isStore = 1'b1; accSize = 2'b10; storeVal = 32'hDEADBEEF;
    memRdata = 32'hCAFEF00D;
    @(negedge clk);
    check("R10 addr", memAddr, 32'h0);
    check("R10 we", {28'd0, byteWe}, 32'h0);
    check("R10 wdata", memWdata, 32'h0);
    check("R10 load", loadResult, 32'h0);
    rstN = 1'b1;
  endtask

  task automatic testByteStores;
    for (int k = 0; k < 4; k++) begin
      run("R3 byte store", 32'h0000_0108 + k, 2'b00, 1'b0, 1'b1, 32'h1234_56A5, 32'h0);
      check("R3 single lane", {28'd0, byteWe}, 32'h8 >> k);
    end
  endtask

  task automatic testHalfStores;
    for (int k = 0; k < 4; k++)
      run("R4 half store", 32'h8000_0010 + k, 2'b01, 1'b0, 1'b1, 32'hFFFF_BEEF, 32'h0);
    run("R4 half off1", 32'h0000_0021, 2'b01, 1'b0, 1'b1, 32'h0000_1357, 32'h0);
    check("R4 off1 mask", {28'd0, byteWe}, 32'hC);
  endtask

  task automatic testWordStores;
    for (int k = 0; k < 4; k++)
      run("R5 word store", 32'h0000_0FF0 + k, 2'b10, 1'b0, 1'b1, 32'hA1B2_C3D4, 32'h0);
    run("R2 spare store", 32'h0000_0003, 2'b11, 1'b0, 1'b1, 32'h0BAD_F00D, 32'h0);
    check("R2 spare mask", {28'd0, byteWe}, 32'hF);
  endtask

  task automatic testByteLoads;
    for (int k = 0; k < 4; k++) begin
      run("R7 byte signed", 32'h0000_0200 + k, 2'b00, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h80FF_7F01);
      run("R7 byte unsigned", 32'h0000_0200 + k, 2'b00, 1'b1, 1'b0, 32'h0, 32'h80FF_7F01);
    end
    run("R7 lb 0xFF", 32'h0000_0001, 2'b00, 1'b0, 1'b0, 32'h0, 32'h00FF_0000);
    check("R7 lb ones", loadResult, 32'hFFFF_FFFF);
    run("R7 lbu 0xFF", 32'h0000_0001, 2'b00, 1'b1, 1'b0, 32'h0, 32'h00FF_0000);
    check("R7 lbu zero", loadResult, 32'h0000_00FF);
  endtask

  task automatic testHalfLoads;
    for (int k = 0; k < 4; k++) begin
      run("R8 half signed", 32'h0000_0400 + k, 2'b01, 1'b0, 1'b0, 32'h0, 32'h9234_7ABC);
      run("R8 half unsigned", 32'h0000_0400 + k, 2'b01, 1'b1, 1'b0, 32'h0, 32'h9234_FABC);
    end
    run("R8 half off3", 32'h0000_0003, 2'b01, 1'b0, 1'b0, 32'h0, 32'h0001_8000);
    check("R8 off3 value", loadResult, 32'hFFFF_8000);
  endtask

  task automatic testWordLoads;
    for (int k = 0; k < 4; k++)
      run("R9 word load", 32'h0000_0800 + k, 2'b10, k[0], 1'b0, 32'h0, 32'hF00D_8123);
    run("R2 spare load", 32'h0000_0002, 2'b11, 1'b0, 1'b0, 32'h0, 32'h89AB_CDEF);
    check("R2 spare load value", loadResult, 32'h89AB_CDEF);
  endtask

  task automatic testLoadNoWrite;
    for (int s = 0; s < 4; s++) begin
      run("R6 load no write", 32'h0000_0C01, s[1:0], 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h1111_2222);
      check("R6 mask clear", {28'd0, byteWe}, 32'h0);
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    testReset();
    testByteStores();
    testHalfStores();
    testWordStores();
    testByteLoads();
    testHalfLoads();
    testWordLoads();
    testLoadNoWrite();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule